// File: doc/BRIEF.md
# Sleep-Aware Converter Sequencer

This block is the digital control for an 8-bit successive-approximation converter in a small microcontroller. Software writes a control byte that selects the conversion clock, the input channel, an enable bit and a start/done bit. An interrupt-enable bit and an interrupt flag sit beside it, together with a result register. Once started, the sequencer drives a trial code toward an external comparator. It settles one bit per conversion-clock period, most significant bit first. When it finishes it stores the code, clears start/done and raises the flag.

A level sleep request from the core changes what happens next, and the selected clock decides how. With the free-running RC source (select `11`) the conversion starts one cycle late, so the core can enter sleep before it begins, and it then runs to the end. At the end it either requests a wake-up or powers the converter down. With any divided clock, sleep aborts the conversion and powers the converter down. In both cases the enable bit stays as it was. A compare-match event from a timer capture/compare unit in its trigger mode always pulses a timer-clear output, and it starts a conversion only when the converter is enabled.

Top module: `adc_sleep_ctl`

## Requirements
- R1: After reset the control byte, interrupt enable, interrupt flag, timer-clear, wake-up and power-down outputs all read 0 and no conversion runs.
- R2: Control byte layout: bits [7:6] clock select, [5:3] channel, [2] start/done, [1] always reads 0, [0] enable; written fields read back unchanged.
- R3: A control write sets start/done only if the same write sets enable to 1; a write with enable 0 leaves both start/done and enable at 0.
- R4: A conversion samples the comparator once per conversion-clock period over 8 periods, MSB first, and yields the largest code the comparator accepts. The periods are 2, 4 and 8 clock cycles for select 00, 01 and 10, and one `rc_tick` pulse for select 11. With a divided clock, start/done reads 1 for exactly 1 + 8·period cycles.
- R5: On completion start/done clears, the result register loads the code and the interrupt flag sets, all in the same cycle.
- R6: With select 11 the first conversion period begins one cycle later than with a divided clock.
- R7: A sleep request while a divided clock is selected aborts any conversion in the next cycle: start/done clears, the result and flag are unchanged, `pwr_down` asserts, and enable stays 1.
- R8: With select 11 a conversion continues through sleep. If the interrupt enable is 1, `wake_req` asserts once the flag is set (wake_req = sleep_req AND flag AND interrupt enable).
- R9: With select 11 and interrupt enable 0, a conversion that ends in sleep is followed one cycle later by `pwr_down` asserting, with enable still 1.
- R10: Capture/compare mode 4'b1011 together with `cmp_match` pulses `tmr_clr` in the next cycle whatever the enable bit is. If enable is 1 it also sets start/done. Any other mode is ignored.
- R11: Software writing start/done to 0 during a conversion aborts it, leaving the result and flag unchanged.
- R12: `pwr_down` is 0 in every cycle following one without a sleep request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | Write `wdata` into the control byte |
| wr_ie | input | 1 | Write `wdata[0]` into the interrupt enable |
| wr_flag | input | 1 | Write `wdata[0]` into the interrupt flag |
| wdata | input | 8 | Write data |
| ctrl_q | output | 8 | Control byte readback |
| ie_q | output | 1 | Interrupt enable |
| flag_q | output | 1 | Interrupt flag |
| result_q | output | RES_W | Last conversion result |
| dac_code | output | RES_W | Trial code presented to the comparator |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial code |
| rc_tick | input | 1 | One pulse per RC conversion-clock period |
| sleep_req | input | 1 | Core is asleep (level) |
| ccp_mode | input | 4 | Capture/compare unit mode field |
| cmp_match | input | 1 | Capture/compare match event |
| tmr_clr | output | 1 | Timer-clear pulse |
| wake_req | output | 1 | Wake-up request to the core |
| pwr_down | output | 1 | Converter in its powered-down state |

## Verification
Conversions are run on each of the four clock selects with input levels 0x00, 0xFF and mid-scale values such as 0xA5 and 0x3C. The end codes separate a correct MSB-first decision from stuck or reversed bits, and the busy lengths separate the three divided clocks from each other and from the RC wait cycle. Sleep is applied to a divided-clock conversion and to RC conversions with the interrupt enable on and off, which separates abort, wake-up and power-down. Triggers are applied with the converter enabled and disabled and with a wrong mode, and a start/done clear mid-conversion checks that an aborted conversion leaves the result and flag unchanged.

// File: rtl/adc_sleep_pkg.sv
package adc_sleep_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [2:0] chan;
        logic       go;
        logic       rsvd;
        logic       en;
    } ctrl_reg_t;

    localparam logic [1:0] CLK_SEL_RC = 2'b11;
    localparam logic [3:0] TRIG_MODE  = 4'b1011;

    function automatic logic is_rc(input logic [1:0] sel);
        return sel == CLK_SEL_RC;
    endfunction

endpackage

// File: rtl/adc_conv_tick.sv
module adc_conv_tick
    import adc_sleep_pkg::*;
#(
    parameter int DIV0 = 2,
    parameter int DIV1 = 4,
    parameter int DIV2 = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] clk_sel,
    input  logic       run,
    input  logic       rc_tick,
    output logic       tick
);
    localparam int DIV01  = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int DIVMAX = (DIV01 > DIV2) ? DIV01 : DIV2;
    localparam int CW     = (DIVMAX > 2) ? $clog2(DIVMAX) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (clk_sel)
            2'b00:   lim = CW'(DIV0 - 1);
            2'b01:   lim = CW'(DIV1 - 1);
            default: lim = CW'(DIV2 - 1);
        endcase
        tick = is_rc(clk_sel) ? rc_tick : (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || is_rc(clk_sel) || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_sleep_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             rc_sel,
    input  logic             tick,
    input  logic             cmp_in,
    input  logic             sleep_req,
    input  logic             wake_hold,
    output logic             conv_run,
    output logic             done_p,
    output logic             abort_p,
    output logic [RES_W-1:0] conv_val,
    output logic [RES_W-1:0] dac_code,
    output logic             pwr_down
);
    localparam int IDX_W = (RES_W > 2) ? $clog2(RES_W) : 1;
    localparam logic [RES_W-1:0] TRIAL_INIT = RES_W'(1) << (RES_W - 1);
    localparam logic [IDX_W-1:0] IDX_INIT   = IDX_W'(RES_W - 1);

    seq_state_e       state_q, state_d;
    logic [RES_W-1:0] trial_q, trial_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             off_q, off_d;

    always_comb begin
        state_d = state_q;
        trial_d = trial_q;
        idx_d   = idx_q;

        abort_p = sleep_req && !rc_sel && (state_q != SEQ_IDLE || go);
        done_p  = (state_q == SEQ_CONV) && go && tick && (idx_q == '0) && !abort_p;

        conv_val        = trial_q;
        conv_val[idx_q] = cmp_in;

        off_d = sleep_req &&
                (off_q || !rc_sel || (state_q == SEQ_IDLE && !go && !wake_hold));

        if (abort_p) begin
            state_d = SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: if (go) begin
                    state_d = rc_sel ? SEQ_WAIT : SEQ_CONV;
                    trial_d = TRIAL_INIT;
                    idx_d   = IDX_INIT;
                end
                SEQ_WAIT: begin
                    state_d = go ? SEQ_CONV : SEQ_IDLE;
                    trial_d = TRIAL_INIT;
                    idx_d   = IDX_INIT;
                end
                SEQ_CONV: begin
                    if (!go) begin
                        state_d = SEQ_IDLE;
                    end else if (tick) begin
                        trial_d = conv_val;
                        if (idx_q == '0) begin
                            state_d = SEQ_IDLE;
                        end else begin
                            idx_d          = idx_q - 1'b1;
                            trial_d[idx_d] = 1'b1;
                        end
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            trial_q <= '0;
            idx_q   <= '0;
            off_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            trial_q <= trial_d;
            idx_q   <= idx_d;
            off_q   <= off_d;
        end
    end

    assign conv_run = (state_q == SEQ_CONV);
    assign dac_code = trial_q;
    assign pwr_down = off_q;
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_sleep_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_ie,
    input  logic             wr_flag,
    input  logic [7:0]       wdata,
    input  logic             trig,
    input  logic             done_p,
    input  logic             abort_p,
    input  logic [RES_W-1:0] conv_val,
    output ctrl_reg_t        ctrl_q,
    output logic             ie_q,
    output logic             flag_q,
    output logic [RES_W-1:0] result_q
);
    ctrl_reg_t ctrl_d;
    ctrl_reg_t wr_view;

    always_comb begin
        wr_view = ctrl_reg_t'(wdata);
        ctrl_d  = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.clk_sel = wr_view.clk_sel;
            ctrl_d.chan    = wr_view.chan;
            ctrl_d.en      = wr_view.en;
            ctrl_d.go      = wr_view.go && wr_view.en;
        end
        if (done_p || abort_p) ctrl_d.go = 1'b0;
        if (trig && ctrl_d.en) ctrl_d.go = 1'b1;
        ctrl_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_ie) ie_q <= wdata[0];
            if (done_p)       flag_q <= 1'b1;
            else if (wr_flag) flag_q <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (done_p) result_q <= conv_val;
    end
endmodule

// File: rtl/adc_sleep_ctl.sv
module adc_sleep_ctl
    import adc_sleep_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int DIV0  = 2,
    parameter int DIV1  = 4,
    parameter int DIV2  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_ie,
    input  logic             wr_flag,
    input  logic [7:0]       wdata,
    output logic [7:0]       ctrl_q,
    output logic             ie_q,
    output logic             flag_q,
    output logic [RES_W-1:0] result_q,
    output logic [RES_W-1:0] dac_code,
    input  logic             cmp_in,
    input  logic             rc_tick,
    input  logic             sleep_req,
    input  logic [3:0]       ccp_mode,
    input  logic             cmp_match,
    output logic             tmr_clr,
    output logic             wake_req,
    output logic             pwr_down
);
    ctrl_reg_t        ctrl_r;
    logic             trig;
    logic             tick;
    logic             conv_run;
    logic             done_p;
    logic             abort_p;
    logic [RES_W-1:0] conv_val;

    assign trig = (ccp_mode == TRIG_MODE) && cmp_match;

    adc_ctrl_regs #(.RES_W(RES_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_ie    (wr_ie),
        .wr_flag  (wr_flag),
        .wdata    (wdata),
        .trig     (trig),
        .done_p   (done_p),
        .abort_p  (abort_p),
        .conv_val (conv_val),
        .ctrl_q   (ctrl_r),
        .ie_q     (ie_q),
        .flag_q   (flag_q),
        .result_q (result_q)
    );

    adc_conv_tick #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (ctrl_r.clk_sel),
        .run     (conv_run),
        .rc_tick (rc_tick),
        .tick    (tick)
    );

    adc_sar_seq #(.RES_W(RES_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (ctrl_r.go),
        .rc_sel    (is_rc(ctrl_r.clk_sel)),
        .tick      (tick),
        .cmp_in    (cmp_in),
        .sleep_req (sleep_req),
        .wake_hold (flag_q && ie_q),
        .conv_run  (conv_run),
        .done_p    (done_p),
        .abort_p   (abort_p),
        .conv_val  (conv_val),
        .dac_code  (dac_code),
        .pwr_down  (pwr_down)
    );

    always_ff @(posedge clk) begin
        if (rst) tmr_clr <= 1'b0;
        else     tmr_clr <= trig;
    end

    assign ctrl_q   = ctrl_r;
    assign wake_req = sleep_req && flag_q && ie_q;
endmodule

// File: rtl/adc_sleep_ctl_chk.sv
module adc_sleep_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ctrl_q,
    input logic       flag_q,
    input logic       wr_ctrl,
    input logic       sleep_req,
    input logic [3:0] ccp_mode,
    input logic       cmp_match,
    input logic       tmr_clr,
    input logic       pwr_down,
    input logic       done_p
);
    logic trig_seen;
    assign trig_seen = (ccp_mode == 4'b1011) && cmp_match;

    a_r2_bit1_zero: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[1] == 1'b0);

    a_r3_go_needs_en: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[2] |-> ctrl_q[0]);

    a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (done_p && !trig_seen) |=> (flag_q && !ctrl_q[2]));

    a_r7_sleep_abort: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && ctrl_q[7:6] != 2'b11 && !trig_seen && !wr_ctrl) |=> !ctrl_q[2]);

    a_r10_trig_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_seen |=> tmr_clr);

    a_r10_no_trig_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !trig_seen |=> !tmr_clr);

    a_r12_awake_powered: assert property (@(posedge clk) disable iff (rst)
        !sleep_req |=> !pwr_down);
endmodule

bind adc_sleep_ctl adc_sleep_ctl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .flag_q    (flag_q),
    .wr_ctrl   (wr_ctrl),
    .sleep_req (sleep_req),
    .ccp_mode  (ccp_mode),
    .cmp_match (cmp_match),
    .tmr_clr   (tmr_clr),
    .pwr_down  (pwr_down),
    .done_p    (done_p)
);

// File: tb/test_adc_sleep_ctl.sv
module test_adc_sleep_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_ctrl = 1'b0, wr_ie = 1'b0, wr_flag = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctrl_q, result_q, dac_code;
    logic       ie_q, flag_q, cmp_in, rc_tick, sleep_req = 1'b0;
    logic [3:0] ccp_mode = 4'h0;
    logic       cmp_match = 1'b0;
    logic       tmr_clr, wake_req, pwr_down;
    logic [7:0] vin = 8'h00;
    int         rc_cnt = 0;

    always #4 clk = ~clk;

    always @(posedge clk) rc_cnt <= (rc_cnt == 2) ? 0 : rc_cnt + 1;
    assign rc_tick = (rc_cnt == 2);
    assign cmp_in  = (vin >= dac_code);

    adc_sleep_ctl i_adc_sleep_ctl (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_ie(wr_ie), .wr_flag(wr_flag),
        .wdata(wdata), .ctrl_q(ctrl_q), .ie_q(ie_q), .flag_q(flag_q),
        .result_q(result_q), .dac_code(dac_code), .cmp_in(cmp_in), .rc_tick(rc_tick),
        .sleep_req(sleep_req), .ccp_mode(ccp_mode), .cmp_match(cmp_match),
        .tmr_clr(tmr_clr), .wake_req(wake_req), .pwr_down(pwr_down)
    );

    int    nvec = 0, nbad = 0, cyc = 0;
    bit    fin = 0;
    string phase = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced once per rising edge
    int       m_state = 0, m_cnt = 0, m_step = 0;
    bit [7:0] m_trial = 0, m_res = 0;
    bit [1:0] m_sel = 0;
    bit [2:0] m_chs = 0;
    bit       m_go = 0, m_en = 0, m_flag = 0, m_ie = 0, m_off = 0, m_tclr = 0, m_resv = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cnt = 0; m_step = 0; m_trial = 0;
            m_sel = 0; m_chs = 0; m_go = 0; m_en = 0;
            m_flag = 0; m_ie = 0; m_off = 0; m_tclr = 0; m_resv = 0;
        end else begin
            bit rc, tk, trg, ab, dn, n_off;
            int per;
            rc  = (m_sel == 2'b11);
            per = (m_sel == 0) ? 2 : (m_sel == 1) ? 4 : 8;
            tk  = rc ? rc_tick : (m_cnt == per - 1);
            trg = (ccp_mode == 4'b1011) && cmp_match;
            ab  = sleep_req && !rc && (m_state != 0 || m_go);
            dn  = (m_state == 2) && m_go && tk && (m_step == 7) && !ab;
            n_off = sleep_req && (m_off || !rc || (m_state == 0 && !m_go && !(m_flag && m_ie)));
            if (m_state == 2 && !rc) m_cnt = tk ? 0 : m_cnt + 1;
            else                     m_cnt = 0;
            if (ab) m_state = 0;
            else if (m_state == 0) begin
                if (m_go) begin m_state = rc ? 1 : 2; m_trial = 8'h80; m_step = 0; end
            end else if (m_state == 1) begin
                m_state = m_go ? 2 : 0; m_trial = 8'h80; m_step = 0;
            end else if (!m_go) m_state = 0;
            else if (tk) begin
                if (vin < m_trial) m_trial[7 - m_step] = 1'b0;
                if (m_step == 7) begin
                    m_state = 0; m_res = m_trial; m_resv = 1;
                end else begin
                    m_step++;
                    m_trial[7 - m_step] = 1'b1;
                end
            end
            m_off = n_off;
            if (wr_ctrl) begin
                m_sel = wdata[7:6]; m_chs = wdata[5:3];
                m_en = wdata[0]; m_go = wdata[2] & wdata[0];
            end
            if (dn || ab) m_go = 0;
            if (trg && m_en) m_go = 1;
            if (dn) m_flag = 1; else if (wr_flag) m_flag = wdata[0];
            if (wr_ie) m_ie = wdata[0];
            m_tclr = trg;
        end
    end

    // Cycle-by-cycle comparison and watchdog
    always @(negedge clk) begin
        cyc++;
        if (!rst && !fin) begin
            chk({phase, " ctrl"}, ctrl_q, {m_sel, m_chs, m_go, 1'b0, m_en});
            chk({phase, " flag"}, flag_q, m_flag);
            chk({phase, " ie"}, ie_q, m_ie);
            chk({phase, " tmr_clr"}, tmr_clr, m_tclr);
            chk({phase, " pwr_down"}, pwr_down, m_off);
            chk({phase, " wake_req"}, wake_req, sleep_req & m_flag & m_ie);
            if (m_resv) chk({phase, " result"}, result_q, m_res);
        end
        if (cyc > 150000 && !fin) begin
            fin = 1;
            nbad++;
            $display("FAIL watchdog (all requirements): got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    task automatic wr_c(input logic [7:0] d);
        @(posedge clk); #1; wr_ctrl = 1; wdata = d;
        @(posedge clk); #1; wr_ctrl = 0;
    endtask

    task automatic wr_i(input logic v);
        @(posedge clk); #1; wr_ie = 1; wdata = {7'd0, v};
        @(posedge clk); #1; wr_ie = 0;
    endtask

    task automatic clr_flag();
        @(posedge clk); #1; wr_flag = 1; wdata = 8'h00;
        @(posedge clk); #1; wr_flag = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        @(negedge clk);
        while (ctrl_q[2] && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_match(input logic [3:0] mode);
        @(posedge clk); #1; ccp_mode = mode; cmp_match = 1;
        @(posedge clk); #1; cmp_match = 0;
    endtask

    initial begin
        int n;
        idle(3);
        rst = 0;
        @(negedge clk);
        phase = "R1";
        chk("R1 reset ctrl", ctrl_q, 8'h00);
        chk("R1 reset flag", flag_q, 1'b0);
        chk("R1 reset pwr_down", pwr_down, 1'b0);

        phase = "R2";
        wr_c(8'b1010_1011);
        @(negedge clk);
        chk("R2 layout readback", ctrl_q, 8'hA9);

        phase = "R3";
        wr_c(8'b0000_0100);
        @(negedge clk);
        chk("R3 go without enable", ctrl_q, 8'h00);
        idle(4);
        chk("R3 still idle", ctrl_q[2], 1'b0);

        phase = "R4";
        foreach (vin[i]) ;
        vin = 8'hA5;
        wr_c(8'b0001_0101);
        wait_done(n);
        chk("R4 busy sel00", n, 17);
        chk("R4 result A5", result_q, 8'hA5);
        chk("R5 flag set", flag_q, 1'b1);
        clr_flag();
        vin = 8'h00;
        wr_c(8'b0100_0101);
        wait_done(n);
        chk("R4 busy sel01", n, 33);
        chk("R4 result 00", result_q, 8'h00);
        clr_flag();
        phase = "R5";
        vin = 8'hFF;
        wr_c(8'b1011_1101);
        wait_done(n);
        chk("R4 busy sel10", n, 65);
        chk("R5 result FF", result_q, 8'hFF);
        chk("R5 flag", flag_q, 1'b1);
        clr_flag();

        phase = "R6";
        vin = 8'h3C;
        wr_c(8'b1100_0101);
        wait_done(n);
        chk("R6 rc result", result_q, 8'h3C);
        clr_flag();

        phase = "R7";
        vin = 8'h5A;
        wr_c(8'b0100_0101);
        idle(5);
        sleep_req = 1;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R7 go cleared", ctrl_q[2], 1'b0);
        chk("R7 enable kept", ctrl_q[0], 1'b1);
        chk("R7 powered down", pwr_down, 1'b1);
        chk("R7 result kept", result_q, 8'h3C);
        chk("R7 flag kept", flag_q, 1'b0);
        phase = "R12";
        sleep_req = 0;
        @(negedge clk);
        chk("R12 awake powered", pwr_down, 1'b0);

        phase = "R8";
        wr_i(1'b1);
        vin = 8'h81;
        wr_c(8'b1100_0101);
        sleep_req = 1;
        n = 0;
        @(negedge clk);
        while (!wake_req && n < 3000) begin n++; @(negedge clk); end
        chk("R8 wake asserted", wake_req, 1'b1);
        chk("R8 result", result_q, 8'h81);
        chk("R8 not powered down", pwr_down, 1'b0);
        sleep_req = 0;
        clr_flag();

        phase = "R9";
        wr_i(1'b0);
        vin = 8'h17;
        wr_c(8'b1100_0101);
        sleep_req = 1;
        wait_done(n);
        chk("R9 result", result_q, 8'h17);
        @(negedge clk);
        chk("R9 powered down", pwr_down, 1'b1);
        chk("R9 enable kept", ctrl_q[0], 1'b1);
        chk("R9 no wake", wake_req, 1'b0);
        sleep_req = 0;
        clr_flag();

        phase = "R10";
        wr_c(8'b0000_0000);
        pulse_match(4'b1011);
        @(negedge clk);
        chk("R10 clear pulse when disabled", tmr_clr, 1'b1);
        chk("R10 no start when disabled", ctrl_q[2], 1'b0);
        vin = 8'hC3;
        wr_c(8'b0000_0001);
        pulse_match(4'b1011);
        chk("R10 start on trigger", ctrl_q[2], 1'b1);
        wait_done(n);
        chk("R10 triggered result", result_q, 8'hC3);
        clr_flag();
        pulse_match(4'b1010);
        @(negedge clk);
        chk("R10 wrong mode ignored", tmr_clr, 1'b0);
        chk("R10 wrong mode no start", ctrl_q[2], 1'b0);

        phase = "R11";
        vin = 8'h66;
        wr_c(8'b1000_0101);
        idle(10);
        wr_c(8'b1000_0001);
        idle(20);
        @(negedge clk);
        chk("R11 result kept", result_q, 8'hC3);
        chk("R11 flag kept", flag_q, 1'b0);
        chk("R11 go clear", ctrl_q[2], 1'b0);

        idle(2);
        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule